// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings that a frequency synthesizer's counters run from: a 9-bit loop-divider value, a 2-bit output-divider code and a 3-bit test-select code. The settings can be written in two ways. A three-wire serial port (shift clock, data, load strobe) fills a 14-bit shift register and commits it to the settings when the load strobe falls. A parallel bus carries only the loop and output divider values. The settings follow that bus while its strobe is low, and the rising edge of the strobe freezes them.

The parallel path always wins. While its strobe is low, serial commits are discarded and the test selection is held cleared. During that time the test pin echoes the top stage of the shift register, so a host can read back the bits it is shifting. Once the parallel strobe is high, the test pin shows a signal picked by the test-select code. All strobe and serial inputs are asynchronous. Each passes through a two-stage synchronizer, and every edge is detected in the single system clock domain.

Top module: `clksyn_cfg`

## Requirements
- R1: While rst_n is low, loop_div_o is all ones, out_div_o is 2'b11, out_ratio_o is 4'b1000 and tst_sel_o is 0, whatever the parallel inputs are.
- R2: Each rising edge of ser_clk_i shifts ser_dat_i into bit 0 of the shift register. The word is sent most significant bit first and is laid out as {test[2:0], out_div[1:0], loop[8:0]}, so loop bit 0 is the last bit sent.
- R3: When par_ld_i is high, a falling edge of ser_ld_i copies the shift register into the three settings. A rising edge of ser_ld_i changes nothing.
- R4: While par_ld_i is low, loop_div_o and out_div_o follow par_loop_i and par_odiv_i, tst_sel_o is held at 0, and serial load edges are ignored.
- R5: The rising edge of par_ld_i freezes the parallel values. Later changes on the parallel bus have no effect while par_ld_i stays high.
- R6: If a serial load falling edge lands in the same cycle as the parallel rising edge, the parallel values are kept and the serial word is discarded.
- R7: out_ratio_o is one-hot and equals 1 shifted left by out_div_o, which gives divide ratios 1, 2, 4 and 8.
- R8: While par_ld_i is low, tst_out_o equals the top bit (bit 13) of the shift register.
- R9: While par_ld_i is high, tst_out_o depends on tst_sel_o: 0 gives 0, 1 gives 1, 2 gives shift register bit 13, 3 gives loop_div_o[0], 4 gives loop_div_o[8], 5 gives out_div_o[0], 6 gives out_div_o[1], and 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_ld_i | input | 1 | Serial load strobe; commits on its falling edge |
| par_ld_i | input | 1 | Parallel load strobe; low means follow, rising edge freezes |
| par_loop_i | input | 9 | Parallel loop-divider value |
| par_odiv_i | input | 2 | Parallel output-divider code |
| loop_div_o | output | 9 | Current loop-divider setting |
| out_div_o | output | 2 | Current output-divider code |
| out_ratio_o | output | 4 | One-hot decoded output divide ratio |
| tst_sel_o | output | 3 | Current test-select code |
| tst_out_o | output | 1 | Test readback pin |

## Verification
The bench goes after edge-polarity mistakes. A design that commits on the rising edge of the serial strobe would change the settings before the falling edge arrives. A design with the word reversed or its fields swapped would scramble the loop value across a sweep of 24 words. The bench drives a serial fall and a parallel rise in the same cycle. A design without parallel priority would take the serial word there. It also commits serial words while the parallel strobe is low and changes the parallel bus after the freeze. A design that let either path through would show the wrong settings. The test pin is read across all eight select codes and during parallel reset, so a design with a misordered test mux or a missing test-latch clear would give the wrong bit.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int CS_M_W  = 9;
  localparam int CS_N_W  = 2;
  localparam int CS_T_W  = 3;
  localparam int CS_SYNC = 2;

  typedef enum logic [CS_T_W-1:0] {
    TS_ZERO = 3'd0,
    TS_ONE  = 3'd1,
    TS_SMSB = 3'd2,
    TS_MLSB = 3'd3,
    TS_MMSB = 3'd4,
    TS_NLSB = 3'd5,
    TS_NMSB = 3'd6,
    TS_IDLE = 3'd7
  } tsel_e;
endpackage

// File: rtl/clksyn_sync.sv
module clksyn_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clksyn_shift.sv
module clksyn_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_s,
  input  logic         sdi_s,
  output logic [W-1:0] word_o,
  output logic         sck_rise_o
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise_o = sck_s & ~sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          word_o <= '0;
    else if (sck_rise_o) word_o <= {word_o[W-2:0], sdi_s};
  end

  // R2: new bit enters at the bottom, older bits move up one place
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_o |=> (word_o[0] == $past(sdi_s)) && (word_o[W-1:1] == $past(word_o[W-2:0])));
endmodule

// File: rtl/clksyn_latch.sv
module clksyn_latch #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int W  = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sld_s,
  input  logic           pld_s,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic [W-1:0]   word,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           par_open_o
);
  logic sld_q, pld_q;
  logic sld_fall, par_take, ser_take, par_done;

  function automatic logic [M_W-1:0] f_m(input logic [W-1:0] w);
    return w[M_W-1:0];
  endfunction
  function automatic logic [N_W-1:0] f_n(input logic [W-1:0] w);
    return w[M_W +: N_W];
  endfunction
  function automatic logic [T_W-1:0] f_t(input logic [W-1:0] w);
    return w[M_W+N_W +: T_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sld_q <= 1'b0;
      pld_q <= 1'b0;
    end else begin
      sld_q <= sld_s;
      pld_q <= pld_s;
    end
  end

  assign sld_fall   = ~sld_s & sld_q;
  assign par_take   = ~pld_q;
  assign par_done   = pld_s & pld_q;
  assign ser_take   = sld_fall & par_done;
  assign par_open_o = ~pld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_o <= '1;
      n_o <= '1;
      t_o <= '0;
    end else if (par_take) begin
      m_o <= par_m;
      n_o <= par_n;
      t_o <= '0;
    end else if (ser_take) begin
      m_o <= f_m(word);
      n_o <= f_n(word);
      t_o <= f_t(word);
    end
  end

  // R3: a serial commit takes every field of the shifted word
  p_ser_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sld_fall && par_done) |=> (m_o == $past(f_m(word))) && (n_o == $past(f_n(word)))
                               && (t_o == $past(f_t(word))));

  // R6: on the parallel rising edge the bus wins over any serial edge
  p_par_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_s && !pld_q) |=> (m_o == $past(par_m)) && (n_o == $past(par_n)) && (t_o == '0));

  // R5: once frozen, nothing but a serial commit moves the settings
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_done && !sld_fall) |=> $stable(m_o) && $stable(n_o) && $stable(t_o));

  // R4: test selection stays cleared while the parallel path is open
  p_tsel_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_s && !pld_q) |=> (t_o == '0));
endmodule

// File: rtl/clksyn_tmux.sv
module clksyn_tmux
  import clksyn_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           par_open,
  input  logic           smsb,
  input  logic [T_W-1:0] tsel,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic           tst_o
);
  function automatic logic f_pick(input logic [T_W-1:0] code, input logic s,
                                  input logic [M_W-1:0] mv, input logic [N_W-1:0] nv);
    case (tsel_e'(code))
      TS_ZERO: return 1'b0;
      TS_ONE:  return 1'b1;
      TS_SMSB: return s;
      TS_MLSB: return mv[0];
      TS_MMSB: return mv[M_W-1];
      TS_NLSB: return nv[0];
      TS_NMSB: return nv[N_W-1];
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    if (par_open) tst_o = smsb;
    else          tst_o = f_pick(tsel, smsb, m, n);
  end
endmodule

// File: rtl/clksyn_cfg.sv
module clksyn_cfg
  import clksyn_pkg::*;
#(
  parameter int M_W    = CS_M_W,
  parameter int N_W    = CS_N_W,
  parameter int T_W    = CS_T_W,
  parameter int STAGES = CS_SYNC,
  localparam int W     = M_W + N_W + T_W,
  localparam int R_W   = 1 << N_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_ld_i,
  input  logic           par_ld_i,
  input  logic [M_W-1:0] par_loop_i,
  input  logic [N_W-1:0] par_odiv_i,
  output logic [M_W-1:0] loop_div_o,
  output logic [N_W-1:0] out_div_o,
  output logic [R_W-1:0] out_ratio_o,
  output logic [T_W-1:0] tst_sel_o,
  output logic           tst_out_o
);
  logic [3:0]   raw, syn;
  logic [W-1:0] word;
  logic         sck_rise, par_open;

  function automatic logic [R_W-1:0] f_ratio(input logic [N_W-1:0] code);
    return R_W'(1) << code;
  endfunction

  assign raw = {par_ld_i, ser_ld_i, ser_dat_i, ser_clk_i};

  clksyn_sync #(.WIDTH(4), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  clksyn_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(syn[0]), .sdi_s(syn[1]),
    .word_o(word), .sck_rise_o(sck_rise)
  );

  clksyn_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sld_s(syn[2]), .pld_s(syn[3]),
    .par_m(par_loop_i), .par_n(par_odiv_i), .word(word),
    .m_o(loop_div_o), .n_o(out_div_o), .t_o(tst_sel_o), .par_open_o(par_open)
  );

  clksyn_tmux #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_tmux (
    .par_open(par_open), .smsb(word[W-1]), .tsel(tst_sel_o),
    .m(loop_div_o), .n(out_div_o), .tst_o(tst_out_o)
  );

  assign out_ratio_o = f_ratio(out_div_o);

  // R7: exactly one ratio line is active
  p_ratio_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_ratio_o) == 1);

  // R2: shift register moves only on a serial clock rise
  p_shift_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(word));
endmodule

// File: tb/clksyn_cfg_test.sv
module clksyn_cfg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
  logic [8:0] par_loop = '0;
  logic [1:0] par_odiv = '0;
  logic [8:0] loop_div;
  logic [1:0] out_div;
  logic [3:0] out_ratio;
  logic [2:0] tst_sel;
  logic       tst_out;
  logic [13:0] mdl;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  clksyn_cfg uut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_i(ser_ld), .par_ld_i(par_ld), .par_loop_i(par_loop), .par_odiv_i(par_odiv),
    .loop_div_o(loop_div), .out_div_o(out_div), .out_ratio_o(out_ratio),
    .tst_sel_o(tst_sel), .tst_out_o(tst_out)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    cyc(3);
    ser_clk = 1'b1;
    cyc(4);
    ser_clk = 1'b0;
    cyc(3);
    mdl = {mdl[12:0], b};
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  function automatic logic exp_tst(input logic [2:0] t, input logic [13:0] w);
    case (t)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return w[13];
      3'd3: return w[0];
      3'd4: return w[8];
      3'd5: return w[9];
      3'd6: return w[10];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk_cfg(input string req, input logic [8:0] m, input logic [1:0] n,
                         input logic [2:0] t);
    chk(req, loop_div, m);
    chk(req, out_div, n);
    chk(req, tst_sel, t);
    chk({req, "/R7"}, out_ratio, 4'b0001 << n);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [13:0] w, w2;
    mdl = '0;
    cyc(4);
    // R1: reset values regardless of bus
    chk("R1 loop", loop_div, 9'h1FF);
    chk("R1 odiv", out_div, 2'b11);
    chk("R1 ratio", out_ratio, 4'b1000);
    chk("R1 tsel", tst_sel, 3'd0);
    rst_n = 1'b1;
    cyc(4);

    // R4: follow the parallel bus while the strobe is low
    for (int i = 0; i < 64; i++) begin
      par_loop = 9'((i * 83 + 5) % 512);
      par_odiv = 2'(i % 4);
      cyc(2);
      chk_cfg("R4 follow", par_loop, par_odiv, 3'd0);
    end

    // R8: readback of the top shift stage while the parallel strobe is low
    for (int i = 0; i < 20; i++) begin
      send_bit(1'((i * 5 + 1) % 3 == 0));
      chk("R8 echo", tst_out, mdl[13]);
    end
    // R4: a serial load during parallel reset is ignored
    par_loop = 9'h0A5;
    par_odiv = 2'd2;
    ser_ld = 1'b1;
    cyc(6);
    ser_ld = 1'b0;
    cyc(6);
    chk_cfg("R4 ignore", 9'h0A5, 2'd2, 3'd0);

    // R5: rising parallel strobe freezes the bus
    par_loop = 9'h13C;
    par_odiv = 2'd1;
    par_ld = 1'b1;
    cyc(6);
    chk_cfg("R5 capture", 9'h13C, 2'd1, 3'd0);
    par_loop = 9'h002;
    par_odiv = 2'd3;
    cyc(6);
    chk_cfg("R5 hold", 9'h13C, 2'd1, 3'd0);

    // R2/R3/R9: serial words across all test codes
    for (int k = 0; k < 24; k++) begin
      w = {3'(k % 8), 2'((k * 3) % 4), 9'((k * 149 + 31) % 512)};
      send_word(w);
      ser_ld = 1'b1;
      cyc(6);
      chk_cfg("R3 rise", (k == 0) ? 9'h13C : loop_div, (k == 0) ? 2'd1 : out_div, tst_sel);
      if (k == 0) chk("R3 no-rise-load", loop_div, 9'h13C);
      ser_ld = 1'b0;
      cyc(6);
      chk_cfg("R2/R3 load", w[8:0], w[10:9], w[13:11]);
      chk("R9 test", tst_out, exp_tst(w[13:11], w));
    end

    // R6: serial fall and parallel rise in the same cycle
    par_ld = 1'b0;
    par_loop = 9'h055;
    par_odiv = 2'd0;
    cyc(6);
    w2 = {3'd4, 2'd3, 9'h1AA};
    send_word(w2);
    ser_ld = 1'b1;
    cyc(6);
    ser_ld = 1'b0;
    par_ld = 1'b1;
    cyc(6);
    chk_cfg("R6 priority", 9'h055, 2'd0, 3'd0);
    chk("R9 zero", tst_out, 1'b0);
    // R3: next serial load goes through after the freeze
    ser_ld = 1'b1;
    cyc(6);
    ser_ld = 1'b0;
    cyc(6);
    chk_cfg("R3 after", 9'h1AA, 2'd3, 3'd4);
    chk("R9 mmsb", tst_out, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule